// File: doc/BRIEF.md
# Serial Quad-Channel DAC Register Loader

This block is the digital front end of a four-channel, 8-bit digital-to-analog converter that is programmed over a three-wire serial link (active-low chip select, serial clock, serial data). A 12-bit command word is shifted in, most significant bit first. When chip select returns high, the word is decoded. Its data byte goes into one of four input registers, and its two active-low shutdown bits update the per-channel software shutdown state.

Each channel is double buffered. An input register feeds a DAC register under a level-sensitive, active-low load strobe. While the strobe is low, the DAC registers follow their input registers, so a word committed at that time reaches the output in the same cycle as its input register. An asynchronous active-low clear zeroes all input and DAC registers. A power-on reset zeroes every register. A hardware shutdown input forces every channel off without touching any stored value.

All serial pins and the load strobe are brought into one system clock through two-flop synchronisers. A three-state frame machine runs on the detected edges. Its states are IDLE (chip select high), SHIFT (chip select low, bits being taken) and COMMIT (one cycle in which the word is applied). It has four transitions:

- IDLE to SHIFT, on the chip-select falling edge.
- SHIFT to COMMIT, on the chip-select rising edge.
- SHIFT stays in SHIFT on each serial-clock rising edge.
- COMMIT always returns to IDLE.

Top module: `quad_dac_loader`

## Requirements
- R1: A frame is taken MSB first on serial-clock rising edges while `cs_n` is low, with word bit 11 = shut-all (active low), bit 10 = shut-addressed (active low), bits 9:8 = channel address, bits 7:0 = data. Serial-clock edges while `cs_n` is high change nothing.
- R2: Only the last 12 bits before `cs_n` rises are used, so a 16-bit frame with four leading extra bits loads its final 12. A frame of fewer than 12 bits is dropped entirely.
- R3: On the `cs_n` rising edge, the data byte is written to the input register selected by the address (00 = channel 0, 01 = channel 1, 10 = channel 2, 11 = channel 3). The other input registers keep their values.
- R4: While `load_n` is high, every DAC register holds. While `load_n` is low, each DAC register follows its input register, and a word committed at that time updates the addressed DAC register together with its input register.
- R5: A committed word with bit 11 = 0 puts all four channels in shutdown. With bit 11 = 1 and bit 10 = 0, only the addressed channel enters shutdown and the others keep their state.
- R6: A committed word with bits 11 and 10 both 1 takes the addressed channel out of software shutdown, and the other channels keep their state.
- R7: A word that asserts shutdown still loads its data byte. DAC registers keep their contents during shutdown, so `dac_code` shows the stored code while `chan_off` flags the channel.
- R8: While `clr_n` is low, all input and DAC registers read 0x00, taking effect without waiting for a clock edge. A frame in progress is not disturbed and commits normally afterwards, and the shutdown state is not changed.
- R9: While `rst_n` is low, all input and DAC registers are 0x00 and no channel is in software shutdown.
- R10: While `hw_off` is high, all four `chan_off` bits are 1 and no register changes. When it falls, `chan_off` returns to the software shutdown state.
- R11: A committed word reaches `dac_code` within 6 system clocks of `cs_n` rising (with `load_n` low), and not within 2. The serial clock runs at no more than one quarter of the system clock rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| clr_n | input | 1 | Clear of input and DAC registers, active low, asynchronous |
| sck | input | 1 | Serial clock, asynchronous to `clk` |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sdi | input | 1 | Serial data, asynchronous |
| load_n | input | 1 | Level-sensitive DAC register load strobe, active low |
| hw_off | input | 1 | Hardware shutdown of all channels, active high |
| dac_code | output | 32 | DAC register codes, channel n in bits 8n+7:8n |
| chan_off | output | 4 | Per-channel shutdown flag, channel n in bit n |

## Verification
The commit of a frame and a level-low load strobe can act in the same cycle. The bench holds `load_n` low across a chip-select rising edge and expects the addressed DAC code to change with its input register, while the other channels keep following their own input registers. A clear can likewise land in the middle of a frame. The bench pulses `clr_n` between serial bits, expects zero codes at once, and expects the same frame to commit its full 12-bit word afterwards. Hardware shutdown is raised over shutdown states already stored by software and judged on `chan_off` both while it is high and after it falls.

// File: rtl/qdl_pkg.sv
package qdl_pkg;

    // Frame machine states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } frame_state_t;

    // Word field positions relative to the word MSB (fixed by the command format)
    localparam int OFF_ALL_FROM_TOP = 0;
    localparam int OFF_ONE_FROM_TOP = 1;

endpackage

// File: rtl/qdl_sync.sv
module qdl_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/qdl_frame_fsm.sv
module qdl_frame_fsm
    import qdl_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_s_n,
    input  logic              sdi_s,
    output logic              commit,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    frame_state_t      state, state_nxt;
    logic              sck_q, cs_q_n;
    logic              sck_rise, cs_rise, cs_fall;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;

    // Edge detection on the synchronised pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            cs_q_n <= 1'b1;
        end else begin
            sck_q  <= sck_s;
            cs_q_n <= cs_s_n;
        end
    end

    assign sck_rise = sck_s & ~sck_q;
    assign cs_rise  = cs_s_n & ~cs_q_n;
    assign cs_fall  = ~cs_s_n & cs_q_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (cs_fall) state_nxt = ST_SHIFT;
            ST_SHIFT:  if (cs_rise) state_nxt = ST_COMMIT;
            ST_COMMIT: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // Shift register and bit counter; cleared only by power-on reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else begin
            if (state == ST_IDLE && cs_fall) begin
                cnt <= '0;
            end else if (state == ST_SHIFT && sck_rise && !cs_rise) begin
                shreg <= {shreg[WORD_W-2:0], sdi_s};
                if (cnt != CNT_FULL) cnt <= cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        commit = (state == ST_COMMIT) && (cnt == CNT_FULL);
        word   = shreg;
    end
endmodule

// File: rtl/qdl_chan_regs.sv
module qdl_chan_regs #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int AW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              commit,
    input  logic              keep_all,
    input  logic              keep_one,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     data,
    input  logic              load_s_n,
    input  logic              hw_off,
    output logic [NCH*DW-1:0] dac_flat,
    output logic [NCH-1:0]    sw_off,
    output logic [NCH-1:0]    off_flags
);
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic [DW-1:0] in_reg, in_nxt, dac_reg;
            logic          hit;

            assign hit    = commit && (addr == AW'(c));
            assign in_nxt = hit ? data : in_reg;

            // Input and DAC registers: reset and clear both zero them
            always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
                if (!rst_n) begin
                    in_reg  <= '0;
                    dac_reg <= '0;
                end else if (!clr_n) begin
                    in_reg  <= '0;
                    dac_reg <= '0;
                end else begin
                    in_reg <= in_nxt;
                    if (!load_s_n) dac_reg <= in_nxt;
                end
            end

            // Software shutdown flag: only power-on reset clears it
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sw_off[c] <= 1'b0;
                end else if (commit) begin
                    if (!keep_all)          sw_off[c] <= 1'b1;
                    else if (hit && !keep_one) sw_off[c] <= 1'b1;
                    else if (hit)           sw_off[c] <= 1'b0;
                end
            end

            assign dac_flat[c*DW +: DW] = dac_reg;
            assign off_flags[c]         = sw_off[c] | hw_off;
        end
    endgenerate
endmodule

// File: rtl/quad_dac_loader.sv
module quad_dac_loader
    import qdl_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DW     = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic              load_n,
    input  logic              hw_off,
    output logic [NCH*DW-1:0] dac_code,
    output logic [NCH-1:0]    chan_off
);
    localparam int AW     = $clog2(NCH);
    localparam int WORD_W = 2 + AW + DW;

    logic [3:0]        pins_s;
    logic              load_s_n, cs_s_n, sck_s, sdi_s;
    logic              commit;
    logic [WORD_W-1:0] word;
    logic [NCH-1:0]    sw_off;

    // {load_n, cs_n, sck, sdi}; strobes idle high, clock and data low
    qdl_sync #(.W(4), .STAGES(STAGES), .RST_VAL(4'b1100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({load_n, cs_n, sck, sdi}),
        .q     (pins_s)
    );

    assign load_s_n = pins_s[3];
    assign cs_s_n   = pins_s[2];
    assign sck_s    = pins_s[1];
    assign sdi_s    = pins_s[0];

    qdl_frame_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_s  (sck_s),
        .cs_s_n (cs_s_n),
        .sdi_s  (sdi_s),
        .commit (commit),
        .word   (word)
    );

    qdl_chan_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .commit    (commit),
        .keep_all  (word[WORD_W-1-OFF_ALL_FROM_TOP]),
        .keep_one  (word[WORD_W-1-OFF_ONE_FROM_TOP]),
        .addr      (word[DW +: AW]),
        .data      (word[DW-1:0]),
        .load_s_n  (load_s_n),
        .hw_off    (hw_off),
        .dac_flat  (dac_code),
        .sw_off    (sw_off),
        .off_flags (chan_off)
    );
endmodule

// File: rtl/qdl_checker.sv
module qdl_checker #(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              hw_off,
    input logic              load_s_n,
    input logic              commit,
    input logic [NCH*DW-1:0] dac_code,
    input logic [NCH-1:0]    chan_off,
    input logic [NCH-1:0]    sw_off
);
    // R10: hardware shutdown forces every channel off
    assert_hw_all_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hw_off |-> (chan_off == {NCH{1'b1}}));

    // R8: clear holds every DAC code at zero
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (dac_code == '0));

    // R4: strobe high keeps DAC registers
    assert_load_hold_R4: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        load_s_n |=> $stable(dac_code));

    // R5/R6: software shutdown only moves on a commit
    assert_off_on_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(sw_off));
endmodule

bind quad_dac_loader qdl_checker #(.NCH(NCH), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n),
    .hw_off   (hw_off),
    .load_s_n (load_s_n),
    .commit   (commit),
    .dac_code (dac_code),
    .chan_off (chan_off),
    .sw_off   (sw_off)
);

// File: tb/sim_quad_dac_loader.sv
`timescale 1ns/1ps
module sim_quad_dac_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0, clr_n = 1'b1, sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic load_n = 1'b1, hw_off = 1'b0;
    logic [31:0] dac_code;
    logic [3:0]  chan_off;

    int errors = 0, checks = 0;
    logic [7:0] m_in [4];
    logic [7:0] m_dac[4];
    logic [3:0] m_off;

    always #4 clk = ~clk;

    quad_dac_loader u0 (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sck(sck), .cs_n(cs_n),
        .sdi(sdi), .load_n(load_n), .hw_off(hw_off),
        .dac_code(dac_code), .chan_off(chan_off)
    );

    function automatic logic [31:0] exp_codes();
        return {m_dac[3], m_dac[2], m_dac[1], m_dac[0]};
    endfunction

    task automatic check(input string tag);
        logic [3:0] eo;
        eo = hw_off ? 4'hF : m_off;
        checks += 2;
        if (dac_code !== exp_codes()) begin
            errors++;
            $display("FAIL %s dac_code actual=%h expected=%h", tag, dac_code, exp_codes());
        end
        if (chan_off !== eo) begin
            errors++;
            $display("FAIL %s chan_off actual=%b expected=%b", tag, chan_off, eo);
        end
    endtask

    task automatic shift_bit(input logic b);
        sdi = b;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (4) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic send(input logic [15:0] bits, input int n);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) shift_bit(bits[i]);
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic model_word(input logic [11:0] w);
        int a;
        a = int'(w[9:8]);
        m_in[a] = w[7:0];
        if (!w[11])      m_off = 4'hF;
        else if (!w[10]) m_off[a] = 1'b1;
        else             m_off[a] = 1'b0;
        if (!load_n) m_dac[a] = w[7:0];
    endtask

    task automatic set_load(input logic v);
        load_n = v;
        repeat (6) @(negedge clk);
        if (!v) for (int c = 0; c < 4; c++) m_dac[c] = m_in[c];
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [11:0] w;
        for (int c = 0; c < 4; c++) begin m_in[c] = 8'h00; m_dac[c] = 8'h00; end
        m_off = 4'h0;
        repeat (3) @(negedge clk);
        check("R9 reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 after reset");

        // R3/R4: sweep channels and data with strobe high, then transfer
        for (int v = 0; v < 6; v++) begin
            for (int c = 0; c < 4; c++) begin
                w = {2'b11, 2'(c), 8'((v * 73 + c * 29 + 5) % 256)};
                model_word(w);
                send({4'h0, w}, 12);
                check("R4 hold with strobe high");
            end
            set_load(1'b0);
            check("R3 transfer per address");
            set_load(1'b1);
        end

        // R1: serial clock with chip select high changes nothing
        for (int i = 0; i < 12; i++) shift_bit(1'b1);
        repeat (10) @(negedge clk);
        set_load(1'b0);
        check("R1 clock ignored while deselected");

        // R4: strobe low, commit updates DAC together with input register
        for (int c = 0; c < 4; c++) begin
            w = {2'b11, 2'(c), 8'(8'hC3 ^ 8'(c * 17))};
            model_word(w);
            send({4'h0, w}, 12);
            check("R4 transparent commit");
        end

        // R2: 16-bit frame with leading extras, then short frame dropped
        w = 12'hE_A5 | 12'h100;
        w = {2'b11, 2'b01, 8'hA5};
        model_word(w);
        send({4'b1001, w}, 16);
        check("R2 last twelve bits");
        send(16'h00FF, 8);
        check("R2 short frame dropped");

        // R11: commit latency
        w = {2'b11, 2'b10, 8'h3C};
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 11; i >= 0; i--) shift_bit(w[i]);
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 not before two clocks");
        model_word(w);
        repeat (4) @(negedge clk);
        check("R11 within six clocks");
        repeat (6) @(negedge clk);

        // R5/R6/R7: sweep shutdown bit pairs over all addresses
        for (int sb = 3; sb >= 0; sb--) begin
            for (int c = 0; c < 4; c++) begin
                w = {2'(sb), 2'(c), 8'(sb * 64 + c * 9 + 1)};
                model_word(w);
                send({4'h0, w}, 12);
                if (sb == 3)      check("R6 wake addressed");
                else if (sb == 2) check("R5 addressed off R7 data loaded");
                else              check("R5 all off R7 data loaded");
            end
        end
        for (int c = 0; c < 2; c++) begin
            w = {2'b11, 2'(c), 8'(c + 8'h70)};
            model_word(w);
            send({4'h0, w}, 12);
            check("R6 wake one keeps others");
        end

        // R10: hardware shutdown over stored state
        hw_off = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 all off");
        w = {2'b11, 2'b11, 8'h99};
        model_word(w);
        send({4'h0, w}, 12);
        check("R10 registers still load");
        hw_off = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 released");

        // R8: clear in the middle of a frame
        w = {2'b11, 2'b00, 8'h5E};
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 11; i >= 6; i--) shift_bit(w[i]);
        clr_n = 1'b0;
        #1;
        for (int c = 0; c < 4; c++) begin m_in[c] = 8'h00; m_dac[c] = 8'h00; end
        check("R8 clear immediate");
        repeat (3) @(negedge clk);
        check("R8 clear held");
        clr_n = 1'b1;
        for (int i = 5; i >= 0; i--) shift_bit(w[i]);
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        model_word(w);
        check("R8 frame survives clear");

        // R9: reset again zeroes everything including shutdown
        w = {2'b01, 2'b10, 8'h11};
        model_word(w);
        send({4'h0, w}, 12);
        check("R5 all off before reset");
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int c = 0; c < 4; c++) begin m_in[c] = 8'h00; m_dac[c] = 8'h00; end
        m_off = 4'h0;
        check("R9 second reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule